// File: doc/BRIEF.md
# Control Register Transfer Unit

This unit executes the two-operand instruction that copies a 32-bit value between a general-purpose register and one of four architectural control registers (CR0, CR2, CR3 and CR4). The caller presents three instruction bytes with a one-cycle `start` strobe: an escape byte, a direction byte and a ModR/M byte. The unit decodes them, latches the operation and stays busy for a fixed number of clocks. In the last busy cycle it performs the transfer, and the following cycle carries a one-cycle `done` pulse.

The unit does not hold the general-purpose registers. It drives an index, reads data from, and writes data to an eight-entry, 32-bit register file that sits outside it. The control register values are always visible on dedicated outputs. A load into CR3 raises a one-cycle request to flush the non-global TLB entries. Each control register has reserved bit positions that a load cannot change. When an instruction completes, the unit reports six arithmetic flags as undefined. Any encoding the unit does not support is rejected with an `illegal` pulse, and no state changes.

Top module: `crx_unit`

## Requirements
- R1: An operation is valid only when the escape byte is 0x0F. The direction byte 0x22 then copies a general-purpose register into a control register, and 0x20 copies a control register into a general-purpose register. Any other escape or direction byte is illegal.
- R2: ModR/M bits [5:3] select the control register: 0 is CR0, 2 is CR2, 3 is CR3, 4 is CR4. Bits [2:0] select the general-purpose register, driven on `gpr_sel`. The transfer always moves all 32 bits.
- R3: If ModR/M bits [7:6] are not 3, or bits [5:3] are 1, 5, 6 or 7, or R1 rejects the bytes, `illegal` pulses high for the one cycle after the start edge. `busy` stays low, no control register changes and no general-purpose register is written.
- R4: On a load, reserved bit positions keep their old value and the incoming data in those positions is ignored. The reserved masks are 0x1FFAFFC0 for CR0, 0x00000000 for CR2, 0x00000FE7 for CR3 and 0xFFC00000 for CR4.
- R5: `tlb_flush_ng` is high for exactly one cycle, the same cycle as `done`, and only for a completed load into CR3.
- R6: Counted from the start edge to the edge that raises `done`, a read of a control register takes 4 clocks. A load takes 22 clocks for CR0 and CR4, and 12 clocks for CR2 and CR3.
- R7: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse with `busy` low. A `start` while busy is ignored.
- R8: `flags_undef` is 6'b111111 in the `done` cycle and zero otherwise. Bits 0 to 5 mark CF, PF, AF, ZF, SF and OF.
- R9: After reset, CR0 holds the `CR0_INIT` value (default 0x00000010) and CR2, CR3 and CR4 hold zero. `busy`, `done`, `illegal` and `tlb_flush_ng` are low.
- R10: A read of a control register asserts `gpr_wr_en` for exactly one cycle, the last busy cycle, with the full control register value on `gpr_wr_data`. A load never writes the general-purpose file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction strobe; bytes sampled on the same edge |
| ins_esc | input | 8 | First opcode byte |
| ins_op | input | 8 | Second opcode byte (direction) |
| ins_modrm | input | 8 | ModR/M byte |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle invalid-encoding pulse |
| gpr_sel | output | 3 | General-purpose register index |
| gpr_rd_data | input | 32 | Read data of the selected general-purpose register |
| gpr_wr_en | output | 1 | General-purpose register write strobe |
| gpr_wr_data | output | 32 | General-purpose register write data |
| cr0_q | output | 32 | Current CR0 |
| cr2_q | output | 32 | Current CR2 |
| cr3_q | output | 32 | Current CR3 |
| cr4_q | output | 32 | Current CR4 |
| tlb_flush_ng | output | 1 | Flush request for non-global TLB entries |
| flags_undef | output | 6 | Undefined-flag mask |

## Verification
Two situations are hardest to reach from the ports. The first is that reserved bits survive a load only when earlier loads have left the register in a varied state. The bench therefore sweeps every ModR/M reg and r/m combination in both directions, in two passes, with a fresh data pattern before each load, so every load lands on a register an earlier sweep step has changed. The second is the `start` that arrives while busy. It is driven one cycle into a CR3 load, with a CR2 load encoded in it, and the bench confirms that the latency, the flush and CR2 all stay as if the second strobe never came.

// File: rtl/crx_pkg.sv
package crx_pkg;

    localparam int DW      = 32;
    localparam int GPR_AW  = 3;
    localparam int CR_N    = 4;
    localparam int FLAG_N  = 6;

    localparam logic [7:0] BYTE_ESC     = 8'h0F;
    localparam logic [7:0] BYTE_TO_CR   = 8'h22;
    localparam logic [7:0] BYTE_FROM_CR = 8'h20;
    localparam logic [1:0] MOD_REGREG   = 2'b11;

    typedef enum logic [1:0] {
        CRI_0 = 2'd0,
        CRI_2 = 2'd1,
        CRI_3 = 2'd2,
        CRI_4 = 2'd3
    } cr_idx_e;

    typedef struct packed {
        logic                to_cr;
        cr_idx_e             cr;
        logic [GPR_AW-1:0]   gpr;
    } xfer_op_t;

    typedef struct packed {
        logic       ok;
        cr_idx_e    idx;
    } cr_sel_t;

    function automatic cr_sel_t map_cr_field(input logic [2:0] f);
        cr_sel_t s;
        s.ok  = 1'b1;
        s.idx = CRI_0;
        case (f)
            3'd0:    s.idx = CRI_0;
            3'd2:    s.idx = CRI_2;
            3'd3:    s.idx = CRI_3;
            3'd4:    s.idx = CRI_4;
            default: s.ok  = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/crx_decode.sv
module crx_decode
    import crx_pkg::*;
(
    input  logic [7:0] esc_byte,
    input  logic [7:0] op_byte,
    input  logic [7:0] modrm_byte,
    output logic       op_ok,
    output xfer_op_t   op
);
    logic [1:0] mod_f;
    logic [2:0] reg_f;
    logic [2:0] rm_f;
    cr_sel_t    sel;
    logic       dir_ok;

    always_comb begin
        mod_f    = modrm_byte[7:6];
        reg_f    = modrm_byte[5:3];
        rm_f     = modrm_byte[2:0];
        sel      = map_cr_field(reg_f);
        dir_ok   = (op_byte == BYTE_TO_CR) || (op_byte == BYTE_FROM_CR);
        op.to_cr = (op_byte == BYTE_TO_CR);
        op.cr    = sel.idx;
        op.gpr   = rm_f;
        op_ok    = (esc_byte == BYTE_ESC) && dir_ok
                   && (mod_f == MOD_REGREG) && sel.ok;
    end

endmodule

// File: rtl/crx_seq.sv
module crx_seq
    import crx_pkg::*;
#(
    parameter int              RD_LAT      = 4,
    parameter int              WR_LAT      = 12,
    parameter int              WR_LAT_SLOW = 22,
    parameter logic [CR_N-1:0] SLOW_SET    = 4'b1001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dec_ok,
    input  xfer_op_t          dec_op,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              commit,
    output xfer_op_t          cur_op,
    output logic              flush,
    output logic [FLAG_N-1:0] undef_mask
);
    localparam int MAX_A = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
    localparam int MAX_L = (MAX_A > WR_LAT_SLOW) ? MAX_A : WR_LAT_SLOW;
    localparam int CW    = $clog2(MAX_L + 1);

    logic [CW-1:0] cnt;

    function automatic logic [CW-1:0] first_count(input xfer_op_t o);
        int l;
        if (!o.to_cr)
            l = RD_LAT;
        else if (SLOW_SET[o.cr])
            l = WR_LAT_SLOW;
        else
            l = WR_LAT;
        return CW'(l - 1);
    endfunction

    assign commit = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            illegal    <= 1'b0;
            flush      <= 1'b0;
            undef_mask <= '0;
            cnt        <= '0;
            cur_op     <= '0;
        end else begin
            done       <= 1'b0;
            illegal    <= 1'b0;
            flush      <= 1'b0;
            undef_mask <= '0;
            if (busy) begin
                if (cnt == '0) begin
                    busy       <= 1'b0;
                    done       <= 1'b1;
                    undef_mask <= '1;
                    flush      <= cur_op.to_cr && (cur_op.cr == CRI_3);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (start) begin
                if (dec_ok) begin
                    busy   <= 1'b1;
                    cur_op <= dec_op;
                    cnt    <= first_count(dec_op);
                end else begin
                    illegal <= 1'b1;
                end
            end
        end
    end

    AST_FLUSH_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        flush |-> done); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit) |=> busy); // R7
    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !busy); // R3
    AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        (undef_mask != '0) |-> done); // R8

endmodule

// File: rtl/crx_regbank.sv
module crx_regbank
    import crx_pkg::*;
#(
    parameter logic [CR_N-1:0][DW-1:0] INIT = '0,
    parameter logic [CR_N-1:0][DW-1:0] RSV  = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  cr_idx_e                  wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  cr_idx_e                  rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic [CR_N-1:0][DW-1:0]  q
);
    for (genvar i = 0; i < CR_N; i++) begin : g_cr
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= INIT[i];
            else if (wr_en && (wr_idx == cr_idx_e'(i)))
                q[i] <= (wr_data & ~RSV[i]) | (q[i] & RSV[i]);
        end

        AST_RSV_HOLD: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((q[i] & RSV[i]) == ($past(q[i]) & RSV[i]))); // R4
    end

    assign rd_data = q[rd_idx];

endmodule

// File: rtl/crx_unit.sv
module crx_unit
    import crx_pkg::*;
#(
    parameter int              RD_LAT      = 4,
    parameter int              WR_LAT      = 12,
    parameter int              WR_LAT_SLOW = 22,
    parameter logic [CR_N-1:0] SLOW_SET    = 4'b1001,
    parameter logic [31:0]     CR0_INIT    = 32'h0000_0010,
    parameter logic [31:0]     RSV_CR0     = 32'h1FFA_FFC0,
    parameter logic [31:0]     RSV_CR2     = 32'h0000_0000,
    parameter logic [31:0]     RSV_CR3     = 32'h0000_0FE7,
    parameter logic [31:0]     RSV_CR4     = 32'hFFC0_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  ins_esc,
    input  logic [7:0]  ins_op,
    input  logic [7:0]  ins_modrm,
    output logic        busy,
    output logic        done,
    output logic        illegal,
    output logic [2:0]  gpr_sel,
    input  logic [31:0] gpr_rd_data,
    output logic        gpr_wr_en,
    output logic [31:0] gpr_wr_data,
    output logic [31:0] cr0_q,
    output logic [31:0] cr2_q,
    output logic [31:0] cr3_q,
    output logic [31:0] cr4_q,
    output logic        tlb_flush_ng,
    output logic [5:0]  flags_undef
);
    localparam logic [CR_N-1:0][DW-1:0] INIT_ALL = {32'h0, 32'h0, 32'h0, CR0_INIT};
    localparam logic [CR_N-1:0][DW-1:0] RSV_ALL  = {RSV_CR4, RSV_CR3, RSV_CR2, RSV_CR0};

    logic                     dec_ok;
    xfer_op_t                 dec_op;
    xfer_op_t                 cur_op;
    logic                     commit;
    logic [DW-1:0]            cr_rd;
    logic [CR_N-1:0][DW-1:0]  cr_all;

    crx_decode u_dec (
        .esc_byte   (ins_esc),
        .op_byte    (ins_op),
        .modrm_byte (ins_modrm),
        .op_ok      (dec_ok),
        .op         (dec_op)
    );

    crx_seq #(
        .RD_LAT      (RD_LAT),
        .WR_LAT      (WR_LAT),
        .WR_LAT_SLOW (WR_LAT_SLOW),
        .SLOW_SET    (SLOW_SET)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dec_ok     (dec_ok),
        .dec_op     (dec_op),
        .busy       (busy),
        .done       (done),
        .illegal    (illegal),
        .commit     (commit),
        .cur_op     (cur_op),
        .flush      (tlb_flush_ng),
        .undef_mask (flags_undef)
    );

    crx_regbank #(
        .INIT (INIT_ALL),
        .RSV  (RSV_ALL)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (commit && cur_op.to_cr),
        .wr_idx  (cur_op.cr),
        .wr_data (gpr_rd_data),
        .rd_idx  (cur_op.cr),
        .rd_data (cr_rd),
        .q       (cr_all)
    );

    assign gpr_sel     = cur_op.gpr;
    assign gpr_wr_en   = commit && !cur_op.to_cr;
    assign gpr_wr_data = cr_rd;
    assign cr0_q       = cr_all[0];
    assign cr2_q       = cr_all[1];
    assign cr3_q       = cr_all[2];
    assign cr4_q       = cr_all[3];

    AST_GPR_WR_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        gpr_wr_en |=> done); // R10
    AST_GPR_WR_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        gpr_wr_en |-> busy); // R10
    AST_ILLEGAL_NO_CR_CHANGE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(cr_all)); // R3

endmodule

// File: tb/test_crx_unit.sv
`timescale 1ns/1ps
module test_crx_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  ins_esc = 8'h00;
    logic [7:0]  ins_op = 8'h00;
    logic [7:0]  ins_modrm = 8'h00;
    logic        busy, done, illegal, gpr_wr_en, tlb_flush_ng;
    logic [2:0]  gpr_sel;
    logic [31:0] gpr_rd_data, gpr_wr_data;
    logic [31:0] cr0_q, cr2_q, cr3_q, cr4_q;
    logic [5:0]  flags_undef;

    logic [31:0] gmem [0:7];
    logic        pre_en = 1'b0;
    logic [2:0]  pre_idx = 3'd0;
    logic [31:0] pre_val = 32'h0;
    int          wr_cnt = 0;
    int          done_cnt = 0;
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    int          seq_n = 0;
    logic [31:0] model [0:3];
    logic [31:0] rsv   [0:3];

    always #2 clk = ~clk;

    crx_unit i_crx_unit (
        .clk(clk), .rst(rst), .start(start),
        .ins_esc(ins_esc), .ins_op(ins_op), .ins_modrm(ins_modrm),
        .busy(busy), .done(done), .illegal(illegal),
        .gpr_sel(gpr_sel), .gpr_rd_data(gpr_rd_data),
        .gpr_wr_en(gpr_wr_en), .gpr_wr_data(gpr_wr_data),
        .cr0_q(cr0_q), .cr2_q(cr2_q), .cr3_q(cr3_q), .cr4_q(cr4_q),
        .tlb_flush_ng(tlb_flush_ng), .flags_undef(flags_undef)
    );

    assign gpr_rd_data = gmem[gpr_sel];

    always @(posedge clk) begin
        if (pre_en) gmem[pre_idx] <= pre_val;
        if (gpr_wr_en) begin
            gmem[gpr_sel] <= gpr_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cr_port(input int k);
        case (k)
            0: return cr0_q;
            1: return cr2_q;
            2: return cr3_q;
            default: return cr4_q;
        endcase
    endfunction

    task automatic check_crs(input string req);
        for (int k = 0; k < 4; k++) check(req, cr_port(k), model[k]);
    endtask

    task automatic preload(input logic [2:0] idx, input logic [31:0] v);
        pre_en = 1'b1; pre_idx = idx; pre_val = v;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // Runs one instruction starting at a negedge; ends at a negedge with the unit idle.
    task automatic run_op(input logic [7:0] esc, input logic [7:0] code, input logic [7:0] mrm);
        logic [2:0]  regf;
        logic [2:0]  rmf;
        logic        to_cr, ok;
        int          k, lat_exp, lat, w0;
        logic [31:0] g;
        regf  = mrm[5:3];
        rmf   = mrm[2:0];
        to_cr = (code == 8'h22);
        k = (regf == 3'd0) ? 0 : (regf == 3'd2) ? 1 : (regf == 3'd3) ? 2 : 3;
        ok = (esc == 8'h0F) && (code == 8'h22 || code == 8'h20) && (mrm[7:6] == 2'b11)
             && (regf == 3'd0 || regf == 3'd2 || regf == 3'd3 || regf == 3'd4);
        seq_n++;
        g = (32'(seq_n) * 32'h9E37_79B9) ^ 32'h5A5A_A5A5;
        if (to_cr) preload(rmf, g);
        g = gmem[rmf];
        w0 = wr_cnt;
        start = 1'b1; ins_esc = esc; ins_op = code; ins_modrm = mrm;
        @(negedge clk);
        start = 1'b0;
        if (!ok) begin
            check("R3 illegal pulse", {31'b0, illegal}, 32'd1);
            check("R3 busy low", {31'b0, busy}, 32'd0);
            @(negedge clk);
            check("R3 illegal single", {31'b0, illegal}, 32'd0);
            check_crs("R3 no cr change");
            check("R3 no gpr write", 32'(wr_cnt - w0), 32'd0);
        end else begin
            check("R7 busy after start", {31'b0, busy}, 32'd1);
            lat = 0;
            while (!done && lat < 60) begin
                if (tlb_flush_ng || flags_undef != 6'd0) begin
                    check("R5/R8 quiet while busy", {25'b0, tlb_flush_ng, flags_undef}, 32'd0);
                end
                @(negedge clk);
                lat++;
            end
            if (!to_cr) lat_exp = 4;
            else if (k == 0 || k == 3) lat_exp = 22;
            else lat_exp = 12;
            check("R6 latency", 32'(lat), 32'(lat_exp));
            check("R7 busy low at done", {31'b0, busy}, 32'd0);
            check("R5 flush", {31'b0, tlb_flush_ng}, {31'b0, (to_cr && k == 2)});
            check("R8 undefined flags", {26'b0, flags_undef}, 32'h3F);
            if (to_cr) begin
                model[k] = (g & ~rsv[k]) | (model[k] & rsv[k]);
                check("R10 no gpr write on load", 32'(wr_cnt - w0), 32'd0);
            end else begin
                check("R2 gpr receives cr", gmem[rmf], model[k]);
                check("R10 single gpr write", 32'(wr_cnt - w0), 32'd1);
            end
            check_crs("R2/R4 cr values");
            @(negedge clk);
            check("R7 done single", {31'b0, done}, 32'd0);
        end
    endtask

    initial begin
        int d0;
        rsv[0] = 32'h1FFA_FFC0; rsv[1] = 32'h0; rsv[2] = 32'h0000_0FE7; rsv[3] = 32'hFFC0_0000;
        model[0] = 32'h0000_0010; model[1] = 0; model[2] = 0; model[3] = 0;
        for (int i = 0; i < 8; i++) gmem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check_crs("R9 reset cr");
        check("R9 reset ctl", {28'b0, busy, done, illegal, tlb_flush_ng}, 32'd0);

        // R1 R2 R4 R5 R6 sweep over every reg/rm pair, both directions, two passes
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 8; r++)
                for (int m = 0; m < 8; m++) begin
                    run_op(8'h0F, 8'h22, {2'b11, 3'(r), 3'(m)});
                    run_op(8'h0F, 8'h20, {2'b11, 3'(r), 3'(m)});
                end

        // R3 mod field other than 11
        for (int md = 0; md < 3; md++) begin
            run_op(8'h0F, 8'h22, {2'(md), 3'd3, 3'd1});
            run_op(8'h0F, 8'h20, {2'(md), 3'd0, 3'd2});
        end
        // R1 bad escape or direction byte
        run_op(8'h0E, 8'h22, 8'hD9);
        run_op(8'h0F, 8'h21, 8'hC0);
        run_op(8'h0F, 8'h23, 8'hE2);

        // R7 start while busy is ignored
        preload(3'd1, 32'hFFFF_FFFF);
        preload(3'd2, 32'h1234_5678);
        d0 = done_cnt;
        start = 1'b1; ins_esc = 8'h0F; ins_op = 8'h22; ins_modrm = {2'b11, 3'd3, 3'd1};
        @(negedge clk);
        ins_modrm = {2'b11, 3'd2, 3'd2};
        @(negedge clk);
        start = 1'b0;
        begin
            int c;
            c = 1;
            while (!done && c < 60) begin
                @(negedge clk);
                c++;
            end
            check("R7 latency unaffected", 32'(c), 32'd12);
            check("R5 flush on CR3", {31'b0, tlb_flush_ng}, 32'd1);
        end
        model[2] = (32'hFFFF_FFFF & ~rsv[2]) | (model[2] & rsv[2]);
        repeat (30) @(negedge clk);
        check_crs("R7 second start ignored");
        check("R7 one done only", 32'(done_cnt - d0), 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule